// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block chooses which of two reference clocks, a primary and a backup, feeds a downstream clock consumer. It does not pass the clocks itself. It drives a select line to an external glitch-free clock multiplexer and reports which input is in use. Each reference is watched from a free-running monitor clock. Reference edges cross into that domain through toggle synchronizers. A per-input missing-edge detector then judges each reference good or bad.

Three policies are available. In automatic mode the block leaves a failed reference on its own. In manual mode only a qualified external request moves the select. The third mode is automatic switching that the external request can hold off while it is high. Every switch can be postponed by a programmable count of monitor cycles.

Top module: `refsel_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with both references running, `sel_o` and `active_o` read 0 (primary) and `bad_o` reads 2'b00.
- R2: `mode_i` selects the policy: 2'b00 is automatic, 2'b01 is manual, 2'b10 is automatic with request override, and 2'b11 behaves as automatic. In automatic operation, suppose the flag of the selected input rises while the other input's flag is 0. Then `sel_o` and `active_o` move to the other input exactly D+1 monitor cycles after that flag rises, where D = `sw_delay_i` (0 to 7). `active_o` always equals `sel_o`: 0 means the primary and 1 means the backup.
- R3: `bad_o[i]` (bit 0 is the primary, bit 1 is the backup) becomes 1 once `loss_limit_i` monitor cycles pass with no detected edge on that input. While an input toggles with a period well below the limit, its flag stays 0.
- R4: A set flag returns to 0 after GOOD_EDGES (default 4) further detected edges. A recovered input does not pull the select back to it.
- R5: In automatic operation, when both flags are 1 the select holds its value.
- R6: In override mode, while the synchronized `sw_req_i` is high, the select never changes even if the selected input is flagged bad. After the request falls, automatic switching resumes.
- R7: In manual mode, each low-to-high transition of `sw_req_i` that stays high for at least HOLD_CYCLES (default 3) monitor cycles toggles the select exactly once, however long the request stays high. A request high for 2 cycles or fewer has no effect. In the automatic modes the request never moves the select.
- R8: In override mode, a switch that is waiting out its delay is abandoned when the request goes high. The select keeps its value, and a fresh switch starts after the request falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_i | input | 1 | Primary reference clock |
| ref_b_i | input | 1 | Backup reference clock |
| mode_i | input | 2 | Switchover policy (see R2) |
| sw_req_i | input | 1 | Asynchronous external switch request |
| sw_delay_i | input | DELAY_W (3) | Extra monitor cycles before the select changes |
| loss_limit_i | input | LIMIT_W (8) | Edge-free monitor cycles that mark an input bad |
| sel_o | output | 1 | Select to the external clock multiplexer |
| active_o | output | 1 | Input in use: 0 primary, 1 backup |
| bad_o | output | 2 | Per-input loss flags, bit 0 primary |

## Verification
The two functions that can coincide are the delayed automatic switch and the override request. The request can arrive while the switch sequencer is still counting down. The bench sets the delay to its maximum and stops the active reference. It raises the request in the cycle the loss flag appears, so the synchronized request lands inside the countdown. It then checks that the select never moved and that the switch completes only after the request is released.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   typedef enum logic [1:0] {
      MODE_AUTO     = 2'b00,
      MODE_MANUAL   = 2'b01,
      MODE_OVERRIDE = 2'b10,
      MODE_AUTO_ALT = 2'b11
   } refsel_mode_e;
endpackage

// File: rtl/refsel_edge_sync.sv
module refsel_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic ref_clk,
   input  logic mon_clk,
   input  logic rst_n,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("refsel_edge_sync: STAGES must be at least 2");
   end

   logic            tgl_q;
   logic [STAGES:0] chain_q;

   // one toggle per reference rising edge, in the reference domain
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= ~tgl_q;
   end

   // synchronizer plus one history flop for the change detector
   always_ff @(posedge mon_clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], tgl_q};
   end

   assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/refsel_loss_det.sv
module refsel_loss_det #(
   parameter int LIMIT_W    = 8,
   parameter int GOOD_EDGES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               edge_i,
   input  logic [LIMIT_W-1:0] limit_i,
   output logic               bad_o
);
   localparam int GW = $clog2(GOOD_EDGES + 1);
   localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_EDGES - 1);

   if (GOOD_EDGES < 1) begin : g_bad_good
      $error("refsel_loss_det: GOOD_EDGES must be at least 1");
   end

   logic [LIMIT_W-1:0] gap_q;
   logic [GW-1:0]      good_q;
   logic               bad_q;
   logic               gap_expired;

   assign gap_expired = ({1'b0, gap_q} + 1'b1) >= {1'b0, limit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         good_q <= '0;
         bad_q  <= 1'b0;
      end else if (edge_i) begin
         gap_q <= '0;
         if (bad_q) begin
            if (good_q == GOOD_LAST) begin
               bad_q  <= 1'b0;
               good_q <= '0;
            end else begin
               good_q <= good_q + 1'b1;
            end
         end
      end else begin
         if (gap_q != {LIMIT_W{1'b1}}) gap_q <= gap_q + 1'b1;
         if (gap_expired) begin
            bad_q  <= 1'b1;
            good_q <= '0;
         end
      end
   end

   assign bad_o = bad_q;

   // R3: a flag is only raised in a cycle without a detected edge
   p_bad_on_silence_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_q) |-> !$past(edge_i));
   // R4: a flag is only cleared by a detected edge
   p_good_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bad_q) |-> $past(edge_i));
endmodule

// File: rtl/refsel_req_qual.sv
module refsel_req_qual #(
   parameter int STAGES = 2,
   parameter int HOLD   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic level_o,
   output logic pulse_o
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] HOLD_C  = CW'(HOLD);
   localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD - 1);

   if (STAGES < 2 || HOLD < 1) begin : g_bad_cfg
      $error("refsel_req_qual: STAGES >= 2 and HOLD >= 1 required");
   end

   logic [STAGES-1:0] sync_q;
   logic [CW-1:0]     cnt_q;
   logic              lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[STAGES-2:0], req_i};
   end

   assign lvl = sync_q[STAGES-1];

   // saturated at reset so a request must first be seen low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= HOLD_C;
      else if (!lvl)           cnt_q <= '0;
      else if (cnt_q != HOLD_C) cnt_q <= cnt_q + 1'b1;
   end

   assign level_o = lvl;
   assign pulse_o = lvl && (cnt_q == HOLD_M1);

   // R7: one qualified pulse per request, never two in a row
   p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
   import refsel_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LIMIT_W     = 8,
   parameter int GOOD_EDGES  = 4,
   parameter int HOLD_CYCLES = 3,
   parameter int DELAY_W     = 3
) (
   input  logic               mon_clk,
   input  logic               rst_n,
   input  logic               ref_a_i,
   input  logic               ref_b_i,
   input  logic [1:0]         mode_i,
   input  logic               sw_req_i,
   input  logic [DELAY_W-1:0] sw_delay_i,
   input  logic [LIMIT_W-1:0] loss_limit_i,
   output logic               sel_o,
   output logic               active_o,
   output logic [1:0]         bad_o
);
   localparam int NREF = 2;

   if (DELAY_W < 1 || LIMIT_W < 2) begin : g_bad_cfg
      $error("refsel_ctrl: DELAY_W >= 1 and LIMIT_W >= 2 required");
   end

   logic [NREF-1:0] refs;
   logic [NREF-1:0] edge_w;
   logic [NREF-1:0] bad_w;

   assign refs = {ref_b_i, ref_a_i};

   for (genvar i = 0; i < NREF; i++) begin : g_ref
      refsel_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .ref_clk (refs[i]),
         .mon_clk (mon_clk),
         .rst_n   (rst_n),
         .edge_o  (edge_w[i])
      );
      refsel_loss_det #(.LIMIT_W(LIMIT_W), .GOOD_EDGES(GOOD_EDGES)) u_loss (
         .clk     (mon_clk),
         .rst_n   (rst_n),
         .edge_i  (edge_w[i]),
         .limit_i (loss_limit_i),
         .bad_o   (bad_w[i])
      );
   end

   logic req_lvl, req_pulse;

   refsel_req_qual #(.STAGES(SYNC_STAGES), .HOLD(HOLD_CYCLES)) u_req (
      .clk     (mon_clk),
      .rst_n   (rst_n),
      .req_i   (sw_req_i),
      .level_o (req_lvl),
      .pulse_o (req_pulse)
   );

   refsel_mode_e mode;
   logic auto_en, blocked, want_auto, want_man, start;
   logic sel_q, pending_q;
   logic [DELAY_W-1:0] dcnt_q;

   assign mode      = refsel_mode_e'(mode_i);
   assign blocked   = (mode == MODE_OVERRIDE) && req_lvl;
   assign auto_en   = (mode == MODE_AUTO) || (mode == MODE_AUTO_ALT) ||
                      ((mode == MODE_OVERRIDE) && !req_lvl);
   assign want_auto = auto_en && bad_w[sel_q] && !bad_w[~sel_q];
   assign want_man  = (mode == MODE_MANUAL) && req_pulse;
   assign start     = !pending_q && (want_auto || want_man);

   always_ff @(posedge mon_clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         pending_q <= 1'b0;
         dcnt_q    <= '0;
      end else if (blocked) begin
         pending_q <= 1'b0;
         dcnt_q    <= '0;
      end else if (pending_q) begin
         if (dcnt_q == '0) begin
            sel_q     <= ~sel_q;
            pending_q <= 1'b0;
         end else begin
            dcnt_q <= dcnt_q - 1'b1;
         end
      end else if (start) begin
         if (sw_delay_i == '0) begin
            sel_q <= ~sel_q;
         end else begin
            pending_q <= 1'b1;
            dcnt_q    <= sw_delay_i - 1'b1;
         end
      end
   end

   assign sel_o    = sel_q;
   assign active_o = sel_q;
   assign bad_o    = bad_w;

   // R5: with both inputs bad and nothing pending, automatic mode holds
   p_both_bad_hold_r5: assert property (@(posedge mon_clk) disable iff (!rst_n)
      (!pending_q && auto_en && bad_w == 2'b11) |=> (sel_q == $past(sel_q)));
   // R6: an active override request freezes the select
   p_override_freeze_r6: assert property (@(posedge mon_clk) disable iff (!rst_n)
      blocked |=> $stable(sel_q));
   // R2: the select only moves as the result of a started or pending switch
   p_sel_has_cause_r2: assert property (@(posedge mon_clk) disable iff (!rst_n)
      (sel_q != $past(sel_q)) |-> $past(pending_q || start));
   // R8: a pending switch never survives an override request
   p_cancel_pending_r8: assert property (@(posedge mon_clk) disable iff (!rst_n)
      blocked |=> !pending_q);
endmodule

// File: tb/refsel_ctrl_tb.sv
module refsel_ctrl_tb_top;
   logic       mon_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       ref_a   = 1'b0;
   logic       ref_b   = 1'b0;
   logic       en_a    = 1'b1;
   logic       en_b    = 1'b1;
   logic [1:0] mode    = 2'b00;
   logic       sw_req  = 1'b0;
   logic [2:0] sw_delay = 3'd0;
   logic [7:0] loss_limit = 8'd20;
   logic       sel, active;
   logic [1:0] bad;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   refsel_ctrl dut_i (
      .mon_clk      (mon_clk),
      .rst_n        (rst_n),
      .ref_a_i      (ref_a),
      .ref_b_i      (ref_b),
      .mode_i       (mode),
      .sw_req_i     (sw_req),
      .sw_delay_i   (sw_delay),
      .loss_limit_i (loss_limit),
      .sel_o        (sel),
      .active_o     (active),
      .bad_o        (bad)
   );

   always #4 mon_clk = ~mon_clk;                 // 125 MHz
   always #30 if (en_a) ref_a = ~ref_a;          // 60 ns period
   always #35 if (en_b) ref_b = ~ref_b;          // 70 ns period, within 20 %
   always @(posedge mon_clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge mon_clk);
   endtask

   task automatic set_ref(input int idx, input bit on);
      if (idx == 0) en_a = on; else en_b = on;
   endtask

   function automatic int other(input int s);
      return (s == 0) ? 1 : 0;
   endfunction

   function automatic int expect_manual(input int s, input int len);
      return (len >= 3) ? other(s) : s;
   endfunction

   task automatic pulse_req(input int len);
      @(negedge mon_clk) sw_req = 1'b1;
      wait_cyc(len);
      sw_req = 1'b0;
      wait_cyc(8);
   endtask

   // stop the active reference and time the switch against the flag rise
   task automatic auto_switch(input int d, input logic [1:0] m);
      int s, t0, t1, n;
      mode = m;
      sw_delay = 3'(d);
      wait_cyc(2);
      s = int'(sel);
      set_ref(s, 1'b0);
      for (n = 0; n < 300 && bad[s] !== 1'b1; n++) @(negedge mon_clk);
      t0 = cyc;
      chk(bad[s] === 1'b1, "R3 flag of stopped input", int'(bad[s]), 1);
      for (n = 0; n < 40 && int'(sel) == s; n++) @(negedge mon_clk);
      t1 = cyc;
      chk(t1 - t0 == d + 1, "R2 switch latency after flag", t1 - t0, d + 1);
      chk(active === sel && int'(active) == other(s), "R2 active indicator",
          int'(active), other(s));
      chk(bad[other(s)] === 1'b0, "R3 running input stays good", int'(bad[other(s)]), 0);
      set_ref(s, 1'b1);
      wait_cyc(80);
      chk(bad === 2'b00, "R4 flag clears after edges", int'(bad), 0);
      chk(int'(sel) == other(s), "R4 no return to recovered input", int'(sel), other(s));
   endtask

   initial begin : watchdog
      wait (cyc > 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int s, len, d;
      void'($urandom(32'd5277));
      wait_cyc(1);
      chk(sel === 1'b0 && bad === 2'b00, "R1 state during reset", int'({bad, sel}), 0);
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(60);
      chk(sel === 1'b0 && active === 1'b0, "R1 primary selected", int'(sel), 0);
      chk(bad === 2'b00, "R1 R3 both running are good", int'(bad), 0);

      // R2 directed: zero and maximum delay, then random delays and mode 2'b11
      auto_switch(0, 2'b00);
      auto_switch(7, 2'b00);
      for (int it = 0; it < 8; it++) begin
         d = int'($urandom_range(0, 7));
         auto_switch(d, (it % 2 == 1) ? 2'b11 : 2'b00);
      end

      // R5: both inputs lost, select holds
      mode = 2'b00; sw_delay = 3'd0;
      s = int'(sel);
      set_ref(other(s), 1'b0);
      wait_cyc(60);
      chk(int'(sel) == s, "R5 idle input loss keeps select", int'(sel), s);
      set_ref(s, 1'b0);
      wait_cyc(60);
      chk(bad === 2'b11, "R5 both flags set", int'(bad), 3);
      chk(int'(sel) == s, "R5 select held with both bad", int'(sel), s);
      en_a = 1'b1; en_b = 1'b1;
      wait_cyc(100);
      chk(bad === 2'b00, "R4 both recover", int'(bad), 0);

      // R7: request ignored in automatic mode
      s = int'(sel);
      pulse_req(6);
      chk(int'(sel) == s, "R7 request ignored in auto mode", int'(sel), s);

      // R7: manual qualification, random lengths
      mode = 2'b01;
      wait_cyc(2);
      for (int it = 0; it < 12; it++) begin
         s = int'(sel);
         len = int'($urandom_range(1, 6));
         pulse_req(len);
         chk(int'(sel) == expect_manual(s, len), "R7 manual request length",
             int'(sel), expect_manual(s, len));
      end
      s = int'(sel);
      pulse_req(2);
      chk(int'(sel) == s, "R7 two-cycle request rejected", int'(sel), s);
      pulse_req(3);
      chk(int'(sel) == other(s), "R7 three-cycle request accepted", int'(sel), other(s));
      s = int'(sel);
      pulse_req(20);
      chk(int'(sel) == other(s), "R7 long request toggles once", int'(sel), other(s));

      // R6: override blocks automatic switching
      mode = 2'b10; sw_delay = 3'd0;
      s = int'(sel);
      @(negedge mon_clk) sw_req = 1'b1;
      wait_cyc(5);
      set_ref(s, 1'b0);
      wait_cyc(60);
      chk(bad[s] === 1'b1, "R6 flag rises under override", int'(bad[s]), 1);
      chk(int'(sel) == s, "R6 select frozen by request", int'(sel), s);
      sw_req = 1'b0;
      wait_cyc(12);
      chk(int'(sel) == other(s), "R6 automatic resumes after release", int'(sel), other(s));
      set_ref(s, 1'b1);
      wait_cyc(80);

      // R8: request lands during a pending delayed switch
      sw_delay = 3'd7;
      s = int'(sel);
      set_ref(s, 1'b0);
      for (int n = 0; n < 300 && bad[s] !== 1'b1; n++) @(negedge mon_clk);
      sw_req = 1'b1;
      wait_cyc(20);
      chk(int'(sel) == s, "R8 pending switch cancelled", int'(sel), s);
      sw_req = 1'b0;
      wait_cyc(20);
      chk(int'(sel) == other(s), "R8 switch restarts after release", int'(sel), other(s));
      set_ref(s, 1'b1);
      wait_cyc(80);
      chk(bad === 2'b00, "R4 recovery after override test", int'(bad), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule